// File: doc/BRIEF.md
# Partition Freeze Filter

This block keeps the isolation state of every partition behind a host bridge and applies that state to each transaction crossing the bridge. Each partition number owns two freeze flags. One gates outbound memory-mapped traffic and the other gates inbound DMA and message-signalled interrupt traffic. An error report names a partition and raises both of its flags in one step. Software then lowers either flag on its own through a clear write. This lets it, for example, reopen MMIO access for diagnosis while DMA stays fenced off.

Every transaction presents a partition number, a direction and an operation code. One cycle later the block returns a verdict: pass, drop or fill. A passed transaction keeps its data. A blocked store or interrupt message is dropped. A blocked load is answered with data whose bits are all 1, so the requester never sees an error completion. A combinational status port reads back the two flags of any partition.

Top module: `part_freeze_filter`

## Requirements
- R1: After a synchronous active-low reset, both flags of every partition are 0, and `dec_valid` is 0.
- R2: All 256 partition numbers (0 to 255) hold their own flags. `stat_mmio`/`stat_dma` show the flags of `stat_part` in the same cycle, with no register in the path.
- R3: `frz_valid` sets both flags of `frz_part` at the clock edge. A transaction presented in that same cycle is still judged on the old flags.
- R4: A clear write with `clr_valid` acts on `clr_part`. `clr_sel[0]` clears the MMIO flag and `clr_sel[1]` clears the DMA flag. The other flag of that partition, and every other partition, keep their values.
- R5: When a freeze and a clear name the same partition in the same cycle, both flags end up set. When they name different partitions, both take effect.
- R6: The MMIO flag decides for an outbound transaction (`txn_inb`=0) with op load (00), store (01) or reserved (11). The DMA flag decides for an inbound transaction (`txn_inb`=1), and for op MSI (10) in either direction.
- R7: A blocked store (op 01) or reserved op (11) gives `dec_action`=01 (drop) with `dec_data`=0.
- R8: A blocked load (op 00) gives `dec_action`=10 (fill) with `dec_data` all ones.
- R9: A blocked MSI (op 10) gives `dec_action`=01 (drop) with `dec_data`=0.
- R10: A transaction that is not blocked gives `dec_action`=00 (pass) with `dec_data` equal to its `txn_data`.
- R11: The verdict appears exactly one cycle after `txn_valid`. In a cycle after no transaction, `dec_valid`, `dec_action` and `dec_data` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| frz_valid | input | 1 | Error report: freeze a partition |
| frz_part | input | PART_W | Partition to freeze |
| clr_valid | input | 1 | Clear write strobe |
| clr_part | input | PART_W | Partition whose flags are cleared |
| clr_sel | input | 2 | Bit 0 clears the MMIO flag, bit 1 clears the DMA flag |
| stat_part | input | PART_W | Partition selected for status read |
| stat_mmio | output | 1 | MMIO flag of `stat_part` |
| stat_dma | output | 1 | DMA flag of `stat_part` |
| txn_valid | input | 1 | Transaction present |
| txn_part | input | PART_W | Partition of the transaction |
| txn_inb | input | 1 | 1 = inbound (device to host), 0 = outbound |
| txn_op | input | 2 | 00 load, 01 store, 10 MSI, 11 reserved |
| txn_data | input | DATA_W | Transaction data |
| dec_valid | output | 1 | Verdict valid |
| dec_action | output | 2 | 00 pass, 01 drop, 10 fill |
| dec_data | output | DATA_W | Data passed on, all-ones fill, or 0 |

## Verification
The hardest situations to reach from the ports are the collisions. One is a freeze and a clear striking the same partition in one cycle. Another is a transaction arriving in the very cycle that its partition's flags change, where the verdict must follow the old flags. Random stimulus confines partition numbers to a handful of values, plus the top entry 255, so these collisions occur often. Directed sequences then force each collision on purpose, and set up mixed states where only one flag is set, to show which flag decides for each direction and op.

// File: rtl/pff_pkg.sv
// Package: shared encodings for the partition freeze filter.
// Assumes: 2-bit operation and action codes as listed in the brief.
package pff_pkg;

    // Transaction operation codes
    typedef enum logic [1:0] {
        OP_LOAD  = 2'b00,
        OP_STORE = 2'b01,
        OP_MSI   = 2'b10,
        OP_RSVD  = 2'b11
    } op_e;

    // Verdict codes
    typedef enum logic [1:0] {
        ACT_PASS = 2'b00,
        ACT_DROP = 2'b01,
        ACT_FILL = 2'b10
    } act_e;

endpackage

// File: rtl/pff_freeze_table.sv
// Module: pff_freeze_table
// Holds one MMIO and one DMA freeze flag per partition.
// A freeze sets both flags of one entry. A clear lowers the selected flags
// of one entry. Freeze has priority over clear on the same entry.
// Assumes: synchronous active-low reset; at most one freeze and one clear per cycle.
module pff_freeze_table #(
    parameter int NUM_PART = 256,
    parameter int PART_W   = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                set_valid,
    input  logic [PART_W-1:0]   set_part,
    input  logic                clr_valid,
    input  logic [PART_W-1:0]   clr_part,
    input  logic [1:0]          clr_sel,
    output logic [NUM_PART-1:0] mmio_frz,
    output logic [NUM_PART-1:0] dma_frz
);

    for (genvar i = 0; i < NUM_PART; i++) begin : g_entry
        logic set_hit;
        logic clr_hit;

        // Decode whether this entry is the target of a freeze or a clear
        always_comb begin
            set_hit = set_valid && (set_part == PART_W'(i));
            clr_hit = clr_valid && (clr_part == PART_W'(i));
        end

        // MMIO flag: set on freeze, cleared by select bit 0, freeze wins
        always_ff @(posedge clk) begin
            if (!rst_n)
                mmio_frz[i] <= 1'b0;
            else if (set_hit)
                mmio_frz[i] <= 1'b1;
            else if (clr_hit && clr_sel[0])
                mmio_frz[i] <= 1'b0;
        end

        // DMA flag: set on freeze, cleared by select bit 1, freeze wins
        always_ff @(posedge clk) begin
            if (!rst_n)
                dma_frz[i] <= 1'b0;
            else if (set_hit)
                dma_frz[i] <= 1'b1;
            else if (clr_hit && clr_sel[1])
                dma_frz[i] <= 1'b0;
        end
    end

endmodule

// File: rtl/pff_gate.sv
// Module: pff_gate
// Judges one transaction per cycle against the freeze flags, and registers
// the verdict and its data for the next cycle.
// Assumes: the flag vectors are the table outputs before this edge's update.
module pff_gate
    import pff_pkg::*;
#(
    parameter int NUM_PART = 256,
    parameter int PART_W   = 8,
    parameter int DATA_W   = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PART-1:0] mmio_frz,
    input  logic [NUM_PART-1:0] dma_frz,
    input  logic                txn_valid,
    input  logic [PART_W-1:0]   txn_part,
    input  logic                txn_inb,
    input  logic [1:0]          txn_op,
    input  logic [DATA_W-1:0]   txn_data,
    output logic                dec_valid,
    output logic [1:0]          dec_action,
    output logic [DATA_W-1:0]   dec_data
);

    logic              use_dma;
    logic              blocked;
    act_e              act_d;
    act_e              act_q;
    logic [DATA_W-1:0] data_d;

    // Choose the flag that governs this transaction and look it up
    always_comb begin
        use_dma = txn_inb || (op_e'(txn_op) == OP_MSI);
        blocked = use_dma ? dma_frz[txn_part] : mmio_frz[txn_part];
    end

    // Map blocked state and op code to a verdict and the data to return
    always_comb begin
        act_d  = ACT_PASS;
        data_d = '0;
        if (txn_valid) begin
            if (!blocked) begin
                act_d  = ACT_PASS;
                data_d = txn_data;
            end else if (op_e'(txn_op) == OP_LOAD) begin
                act_d  = ACT_FILL;
                data_d = '1;
            end else begin
                act_d  = ACT_DROP;
                data_d = '0;
            end
        end
    end

    // Register the verdict so it is presented one cycle after the request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dec_valid <= 1'b0;
            act_q     <= ACT_PASS;
            dec_data  <= '0;
        end else begin
            dec_valid <= txn_valid;
            act_q     <= act_d;
            dec_data  <= data_d;
        end
    end

    assign dec_action = act_q;

endmodule

// File: rtl/part_freeze_filter.sv
// Module: part_freeze_filter (top)
// Per-partition freeze state table with a transaction filter and a
// combinational status read of any partition's two flags.
// Assumes: synchronous active-low reset; NUM_PART <= 2**PART_W.
module part_freeze_filter #(
    parameter int NUM_PART = 256,
    parameter int DATA_W   = 32,
    localparam int PART_W  = $clog2(NUM_PART)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frz_valid,
    input  logic [PART_W-1:0] frz_part,
    input  logic              clr_valid,
    input  logic [PART_W-1:0] clr_part,
    input  logic [1:0]        clr_sel,
    input  logic [PART_W-1:0] stat_part,
    output logic              stat_mmio,
    output logic              stat_dma,
    input  logic              txn_valid,
    input  logic [PART_W-1:0] txn_part,
    input  logic              txn_inb,
    input  logic [1:0]        txn_op,
    input  logic [DATA_W-1:0] txn_data,
    output logic              dec_valid,
    output logic [1:0]        dec_action,
    output logic [DATA_W-1:0] dec_data
);

    logic [NUM_PART-1:0] mmio_frz;
    logic [NUM_PART-1:0] dma_frz;

    pff_freeze_table #(
        .NUM_PART (NUM_PART),
        .PART_W   (PART_W)
    ) table_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_valid (frz_valid),
        .set_part  (frz_part),
        .clr_valid (clr_valid),
        .clr_part  (clr_part),
        .clr_sel   (clr_sel),
        .mmio_frz  (mmio_frz),
        .dma_frz   (dma_frz)
    );

    pff_gate #(
        .NUM_PART (NUM_PART),
        .PART_W   (PART_W),
        .DATA_W   (DATA_W)
    ) gate_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .mmio_frz   (mmio_frz),
        .dma_frz    (dma_frz),
        .txn_valid  (txn_valid),
        .txn_part   (txn_part),
        .txn_inb    (txn_inb),
        .txn_op     (txn_op),
        .txn_data   (txn_data),
        .dec_valid  (dec_valid),
        .dec_action (dec_action),
        .dec_data   (dec_data)
    );

    // Status read: show the flags of the selected partition
    always_comb begin
        stat_mmio = mmio_frz[stat_part];
        stat_dma  = dma_frz[stat_part];
    end

endmodule

// File: rtl/part_freeze_filter_chk.sv
// Module: part_freeze_filter_chk
// Assertion checker bound to part_freeze_filter. It relates freeze and
// clear requests to the table state, and the table state to the verdicts.
// Assumes: synchronous active-low reset, checks disabled while in reset.
module part_freeze_filter_chk #(
    parameter int NUM_PART = 256,
    parameter int PART_W   = 8,
    parameter int DATA_W   = 32
) (
    input logic                clk,
    input logic                rst_n,
    input logic                frz_valid,
    input logic [PART_W-1:0]   frz_part,
    input logic                clr_valid,
    input logic [PART_W-1:0]   clr_part,
    input logic [1:0]          clr_sel,
    input logic                txn_valid,
    input logic [PART_W-1:0]   txn_part,
    input logic                txn_inb,
    input logic [1:0]          txn_op,
    input logic [DATA_W-1:0]   txn_data,
    input logic                dec_valid,
    input logic [1:0]          dec_action,
    input logic [DATA_W-1:0]   dec_data,
    input logic [NUM_PART-1:0] mmio_frz,
    input logic [NUM_PART-1:0] dma_frz
);

    logic same_hit;
    logic mmio_now;
    logic dma_now;

    // Collision flag and the two table flags of the transaction's partition
    always_comb begin
        same_hit = frz_valid && clr_valid && (frz_part == clr_part);
        mmio_now = mmio_frz[txn_part];
        dma_now  = dma_frz[txn_part];
    end

    AST_FREEZE_SETS_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
        frz_valid |=> (mmio_frz[$past(frz_part)] && dma_frz[$past(frz_part)])); // R3

    AST_CLEAR_MMIO_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_valid && clr_sel == 2'b01 && !(frz_valid && frz_part == clr_part))
        |=> (!mmio_frz[$past(clr_part)] && dma_frz[$past(clr_part)] == $past(dma_frz[clr_part]))); // R4

    AST_CLEAR_DMA_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_valid && clr_sel == 2'b10 && !(frz_valid && frz_part == clr_part))
        |=> (!dma_frz[$past(clr_part)] && mmio_frz[$past(clr_part)] == $past(mmio_frz[clr_part]))); // R4

    AST_FREEZE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        same_hit |=> (mmio_frz[$past(clr_part)] && dma_frz[$past(clr_part)])); // R5

    AST_MSI_GATED_BY_DMA: assert property (@(posedge clk) disable iff (!rst_n)
        (txn_valid && txn_op == 2'b10 && !dma_now && mmio_now) |=> (dec_action == 2'b00)); // R6

    AST_STORE_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (txn_valid && txn_op[0] && (txn_inb ? dma_now : mmio_now))
        |=> (dec_valid && dec_action == 2'b01 && dec_data == '0)); // R7

    AST_LOAD_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        (txn_valid && txn_op == 2'b00 && (txn_inb ? dma_now : mmio_now))
        |=> (dec_valid && dec_action == 2'b10 && (&dec_data))); // R8

    AST_MSI_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (txn_valid && txn_op == 2'b10 && dma_now)
        |=> (dec_valid && dec_action == 2'b01 && dec_data == '0)); // R9

    AST_PASS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        (txn_valid && !mmio_now && !dma_now)
        |=> (dec_valid && dec_action == 2'b00 && dec_data == $past(txn_data))); // R10

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !txn_valid |=> (!dec_valid && dec_action == 2'b00 && dec_data == '0)); // R11

endmodule

bind part_freeze_filter part_freeze_filter_chk #(
    .NUM_PART (NUM_PART),
    .PART_W   (PART_W),
    .DATA_W   (DATA_W)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .frz_valid  (frz_valid),
    .frz_part   (frz_part),
    .clr_valid  (clr_valid),
    .clr_part   (clr_part),
    .clr_sel    (clr_sel),
    .txn_valid  (txn_valid),
    .txn_part   (txn_part),
    .txn_inb    (txn_inb),
    .txn_op     (txn_op),
    .txn_data   (txn_data),
    .dec_valid  (dec_valid),
    .dec_action (dec_action),
    .dec_data   (dec_data),
    .mmio_frz   (mmio_frz),
    .dma_frz    (dma_frz)
);

// File: tb/part_freeze_filter_tb_top.sv
// Bench for part_freeze_filter: directed collisions plus seeded random
// traffic, checked against a flag model held in the bench.
module part_freeze_filter_tb_top;

    localparam int NP = 256;
    localparam int PW = 8;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          frz_valid, clr_valid, txn_valid, txn_inb;
    logic [PW-1:0] frz_part, clr_part, stat_part, txn_part;
    logic [1:0]    clr_sel, txn_op;
    logic [DW-1:0] txn_data;
    logic          stat_mmio, stat_dma, dec_valid;
    logic [1:0]    dec_action;
    logic [DW-1:0] dec_data;

    int n_tests = 0;
    int n_fail  = 0;

    // Bench model of the flags, and the verdict expected next cycle
    bit          ref_m [NP];
    bit          ref_d [NP];
    bit          pend_v;
    logic [1:0]  pend_act;
    logic [DW-1:0] pend_data;
    string       pend_req;

    always #5 clk = ~clk;

    part_freeze_filter #(.NUM_PART(NP), .DATA_W(DW)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .frz_valid(frz_valid), .frz_part(frz_part),
        .clr_valid(clr_valid), .clr_part(clr_part), .clr_sel(clr_sel),
        .stat_part(stat_part), .stat_mmio(stat_mmio), .stat_dma(stat_dma),
        .txn_valid(txn_valid), .txn_part(txn_part), .txn_inb(txn_inb),
        .txn_op(txn_op), .txn_data(txn_data),
        .dec_valid(dec_valid), .dec_action(dec_action), .dec_data(dec_data)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Expected verdict from the requirements (R6 source selection, R7..R10 codes)
    function automatic logic [1:0] exp_act(bit m, bit d, bit inb, logic [1:0] op);
        bit blk;
        blk = (inb || op == 2'b10) ? d : m;
        if (!blk)            return 2'b00;
        else if (op == 2'b00) return 2'b10;
        else                 return 2'b01;
    endfunction

    function automatic string req_of(logic [1:0] act, logic [1:0] op);
        if (act == 2'b00)      return "R10";
        else if (act == 2'b10) return "R8";
        else if (op == 2'b10)  return "R9";
        else                   return "R7";
    endfunction

    // One cycle: check last verdict and status, then model and drive the next
    task automatic step(input bit fv, input logic [PW-1:0] fp,
                        input bit cv, input logic [PW-1:0] cp, input logic [1:0] cs,
                        input bit tv, input logic [PW-1:0] tp, input bit ti,
                        input logic [1:0] top, input logic [DW-1:0] td,
                        input logic [PW-1:0] sp, input string ctx);
        if (pend_v) begin
            chk(dec_valid == 1'b1, "R11", {"verdict valid ", ctx}, 64'(dec_valid), 64'd1);
            chk(dec_action == pend_act, pend_req, {"action ", ctx}, 64'(dec_action), 64'(pend_act));
            chk(dec_data == pend_data, pend_req, {"data ", ctx}, 64'(dec_data), 64'(pend_data));
        end else begin
            chk(!dec_valid && dec_action == 2'b00 && dec_data == '0, "R11",
                {"idle verdict ", ctx}, {dec_valid, dec_action, dec_data}, 64'd0);
        end
        chk(stat_mmio == ref_m[stat_part] && stat_dma == ref_d[stat_part], "R2",
            {"status ", ctx}, {stat_mmio, stat_dma}, {ref_m[stat_part], ref_d[stat_part]});
        pend_v = tv;
        if (tv) begin
            pend_act  = exp_act(ref_m[tp], ref_d[tp], ti, top);
            pend_data = (pend_act == 2'b00) ? td : (pend_act == 2'b10) ? '1 : '0;
            pend_req  = req_of(pend_act, top);
        end
        if (cv) begin
            if (cs[0]) ref_m[cp] = 1'b0;
            if (cs[1]) ref_d[cp] = 1'b0;
        end
        if (fv) begin
            ref_m[fp] = 1'b1;
            ref_d[fp] = 1'b1;
        end
        frz_valid = fv; frz_part = fp;
        clr_valid = cv; clr_part = cp; clr_sel = cs;
        txn_valid = tv; txn_part = tp; txn_inb = ti; txn_op = top; txn_data = td;
        stat_part = sp;
        @(negedge clk);
    endtask

    task automatic idle(input logic [PW-1:0] sp, input string ctx);
        step(0, 0, 0, 0, 2'b00, 0, 0, 0, 2'b00, '0, sp, ctx);
    endtask

    task automatic txn(input logic [PW-1:0] p, input bit inb, input logic [1:0] op,
                       input logic [DW-1:0] d, input string ctx);
        step(0, 0, 0, 0, 2'b00, 1, p, inb, op, d, p, ctx);
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary
    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        for (int i = 0; i < NP; i++) begin ref_m[i] = 0; ref_d[i] = 0; end
        pend_v = 0; pend_act = 0; pend_data = 0; pend_req = "R10";
        rst_n = 0; frz_valid = 0; frz_part = 0; clr_valid = 0; clr_part = 0;
        clr_sel = 0; stat_part = 0; txn_valid = 0; txn_part = 0; txn_inb = 0;
        txn_op = 0; txn_data = 0;
        // Dirty the table during a first reset window, then reset again
        repeat (2) @(negedge clk);
        rst_n = 1;
        frz_valid = 1; frz_part = 8'd3;
        @(negedge clk);
        frz_valid = 0;
        rst_n = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        // R1: flags clear and no verdict after reset
        chk(dec_valid == 0, "R1", "dec_valid after reset", 64'(dec_valid), 64'd0);
        stat_part = 8'd3; #1;
        chk(!stat_mmio && !stat_dma, "R1", "part 3 flags after reset",
            {stat_mmio, stat_dma}, 64'd0);
        stat_part = 8'd255; #1;
        chk(!stat_mmio && !stat_dma, "R1", "part 255 flags after reset",
            {stat_mmio, stat_dma}, 64'd0);

        // R3: same-cycle transaction sees old state, next cycle sees frozen
        step(1, 8'd5, 0, 0, 2'b00, 1, 8'd5, 0, 2'b00, 32'h1234_5678, 8'd5, "R3 same-cycle load");
        txn(8'd5, 0, 2'b00, 32'hAAAA_0001, "R3 load after freeze");
        txn(8'd5, 1, 2'b01, 32'hAAAA_0002, "R3 inbound store after freeze");
        txn(8'd5, 0, 2'b10, 32'hAAAA_0003, "R9 MSI after freeze");
        txn(8'd5, 0, 2'b11, 32'hAAAA_0004, "R7 reserved op after freeze");

        // R4: clear MMIO only, so outbound passes and inbound stays blocked
        step(0, 0, 1, 8'd5, 2'b01, 0, 0, 0, 2'b00, '0, 8'd5, "R4 clear mmio");
        txn(8'd5, 0, 2'b00, 32'hBBBB_0001, "R4 R6 outbound load passes");
        txn(8'd5, 1, 2'b00, 32'hBBBB_0002, "R4 R6 inbound load filled");
        txn(8'd5, 0, 2'b10, 32'hBBBB_0003, "R6 outbound MSI uses dma flag");
        step(0, 0, 1, 8'd5, 2'b10, 0, 0, 0, 2'b00, '0, 8'd5, "R4 clear dma");
        txn(8'd5, 1, 2'b01, 32'hBBBB_0004, "R4 inbound store passes");

        // R6: only DMA flag left, outbound store passes, inbound MSI dropped
        step(1, 8'd9, 0, 0, 2'b00, 0, 0, 0, 2'b00, '0, 8'd9, "freeze 9");
        step(0, 0, 1, 8'd9, 2'b01, 0, 0, 0, 2'b00, '0, 8'd9, "R6 clear mmio 9");
        txn(8'd9, 0, 2'b01, 32'hCCCC_0001, "R6 outbound store passes");
        txn(8'd9, 1, 2'b10, 32'hCCCC_0002, "R6 inbound MSI dropped");

        // R5: freeze and clear the same partition together, freeze wins
        step(1, 8'd7, 1, 8'd7, 2'b11, 0, 0, 0, 2'b00, '0, 8'd7, "R5 same-part collision");
        idle(8'd7, "R5 status after collision");
        // R5: different partitions both take effect (clear 9 dma, freeze 11)
        step(1, 8'd11, 1, 8'd9, 2'b10, 0, 0, 0, 2'b00, '0, 8'd9, "R5 split collision");
        idle(8'd11, "R5 status of 9");
        idle(8'd11, "R5 status of 11");

        // R2: top partition 255 and its neighbour 254 are independent
        step(1, 8'd255, 0, 0, 2'b00, 0, 0, 0, 2'b00, '0, 8'd254, "R2 freeze 255");
        idle(8'd255, "R2 status 254");
        txn(8'd255, 0, 2'b00, 32'hDDDD_0001, "R2 R8 load to 255");
        txn(8'd254, 0, 2'b00, 32'hDDDD_0002, "R2 R10 load to 254");
        step(0, 0, 1, 8'd255, 2'b11, 0, 0, 0, 2'b00, '0, 8'd255, "R4 clear both 255");
        idle(8'd255, "R4 status 255");

        // Random traffic over a narrow partition set to force collisions
        void'($urandom(32'h5EED_0042));
        for (int k = 0; k < 4000; k++) begin
            logic [PW-1:0] fp, cp, tp, sp;
            bit fv, cv, tv, ti;
            logic [1:0] cs, op;
            fp = ($urandom % 16 == 0) ? 8'd255 : 8'($urandom % 6);
            cp = ($urandom % 16 == 0) ? 8'd255 : 8'($urandom % 6);
            tp = ($urandom % 16 == 0) ? 8'd255 : 8'($urandom % 6);
            sp = 8'($urandom % 6);
            fv = ($urandom % 6 == 0);
            cv = ($urandom % 3 == 0);
            tv = ($urandom % 4 != 0);
            ti = $urandom % 2;
            cs = 2'($urandom);
            op = 2'($urandom);
            step(fv, fp, cv, cp, cs, tv, tp, ti, op, $urandom, sp, "random");
        end
        idle(8'd0, "drain");
        idle(8'd0, "drain");

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule